// File: doc/BRIEF.md
# Out-of-Order Issue Window

This block sits between instruction decode and the execution units. Decode offers one decoded instruction per cycle (unit code, destination register, two source registers) through a valid/ready handshake. The window keeps up to `DEPTH` such instructions and sends one per cycle to the execution units, picking any stored instruction whose operands are available and whose unit is idle, regardless of program order.

Since operands are read when an instruction leaves the window, not when it arrives, an instruction that writes a register cannot be admitted while some stored instruction still has to read that register. It also cannot be admitted while an earlier write to the same register is outstanding. The window keeps one pending-write bit per architectural register. The bit is raised when an instruction is admitted and lowered when the write-back port reports that register. Per-unit busy inputs hold back instructions aimed at occupied units.

Top module: `ooo_issue_buf`

## Requirements
- R1: After reset the window is empty: `in_ready_o` is 1, `full_o` is 0, `disp_valid_o` is 0 and no register has a pending write.
- R2: `full_o` is 1 exactly when all `DEPTH` slots hold instructions; while full and nothing dispatches in the cycle, `in_ready_o` is 0.
- R3: An offered instruction is refused when its destination equals `src1` or `src2` of any instruction held at the start of the cycle, including one that dispatches in that cycle.
- R4: An offered instruction is refused when its destination register has a pending write. A pending write is set when an instruction is accepted and is cleared by a write-back (`wb_valid_i` with `wb_reg_i`).
- R5: A held instruction dispatches only when both sources are ready. A source is ready at acceptance if its register has no pending write or is written back in that same cycle; otherwise it becomes ready through a later write-back of that register.
- R6: At most one instruction dispatches per cycle. Among the eligible ones it is the earliest accepted. The dispatch outputs are combinational from held state and `fu_busy_i`.
- R7: An instruction whose unit code `u` has `fu_busy_i[u]` = 1 is not eligible in that cycle.
- R8: A write-back in cycle t makes a waiting instruction eligible from cycle t+1, not in cycle t.
- R9: A slot vacated by a dispatch in cycle t can accept an offered instruction in the same cycle t, even when the window is full.
- R10: An instruction whose source equals its own destination does not wait on its own pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Decode offers an instruction |
| in_ready_o | output | 1 | Offered instruction is accepted this cycle |
| in_fu_i | input | $clog2(NFU) | Target unit code |
| in_dst_i | input | $clog2(NREG) | Destination register |
| in_src1_i | input | $clog2(NREG) | First source register |
| in_src2_i | input | $clog2(NREG) | Second source register |
| wb_valid_i | input | 1 | Write-back event |
| wb_reg_i | input | $clog2(NREG) | Register being written back |
| fu_busy_i | input | NFU | Per-unit busy, indexed by unit code |
| disp_valid_o | output | 1 | An instruction leaves this cycle |
| disp_fu_o | output | $clog2(NFU) | Unit code of dispatched instruction |
| disp_dst_o | output | $clog2(NREG) | Destination of dispatched instruction |
| disp_src1_o | output | $clog2(NREG) | First source of dispatched instruction |
| disp_src2_o | output | $clog2(NREG) | Second source of dispatched instruction |
| full_o | output | 1 | All slots occupied |

## Verification
The bench builds the window with its defaults: four slots, eight registers and four units. With only eight register names, random traffic runs into read-before-write and write-after-write refusals within a few cycles. Four slots fill quickly whenever the busy inputs hold units back, so the full, same-cycle slot reuse and oldest-first choices all occur often. Directed sequences add the cases that need exact timing: a write-back that wakes a waiting instruction, an instruction that names its own destination as a source, and insertion into a full window in the cycle one entry leaves.

// File: rtl/ib_pkg.sv
package ib_pkg;
  localparam int unsigned IB_DEPTH = 4;
  localparam int unsigned IB_NREG  = 8;
  localparam int unsigned IB_NFU   = 4;
endpackage

// File: rtl/ib_pend_track.sv
module ib_pend_track #(
  parameter int unsigned NREG  = ib_pkg::IB_NREG,
  localparam int unsigned REG_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_v_i,
  input  logic [REG_W-1:0] set_reg_i,
  input  logic             clr_v_i,
  input  logic [REG_W-1:0] clr_reg_i,
  output logic [NREG-1:0]  pend_o
);
  logic [NREG-1:0] pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (set_v_i && set_reg_i == REG_W'(r))      pend_q[r] <= 1'b1;
        else if (clr_v_i && clr_reg_i == REG_W'(r)) pend_q[r] <= 1'b0;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ib_age_arb.sv
module ib_age_arb #(
  parameter int unsigned DEPTH = ib_pkg::IB_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] ins_oh_i,  // slot written this cycle (one-hot or zero)
  input  logic [DEPTH-1:0] keep_i,    // slots still occupied after this cycle's grant
  input  logic [DEPTH-1:0] req_i,
  output logic [DEPTH-1:0] gnt_o
);
  // older_q[j][i]: slot j was accepted before slot i
  logic [DEPTH-1:0] older_q [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++)
        if (j != i && req_i[j] && older_q[j][i]) blocked = 1'b1;
      gnt_o[i] = req_i[i] && !blocked;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int j = 0; j < DEPTH; j++) older_q[j] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (ins_oh_i[k]) begin
          older_q[k] <= '0;
          for (int j = 0; j < DEPTH; j++)
            if (j != k) older_q[j][k] <= keep_i[j];
        end
      end
    end
  end
endmodule

// File: rtl/ooo_issue_buf.sv
module ooo_issue_buf #(
  parameter int unsigned DEPTH = ib_pkg::IB_DEPTH,
  parameter int unsigned NREG  = ib_pkg::IB_NREG,
  parameter int unsigned NFU   = ib_pkg::IB_NFU,
  localparam int unsigned REG_W = $clog2(NREG),
  localparam int unsigned FU_W  = $clog2(NFU)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [FU_W-1:0]  in_fu_i,
  input  logic [REG_W-1:0] in_dst_i,
  input  logic [REG_W-1:0] in_src1_i,
  input  logic [REG_W-1:0] in_src2_i,
  input  logic             wb_valid_i,
  input  logic [REG_W-1:0] wb_reg_i,
  input  logic [NFU-1:0]   fu_busy_i,
  output logic             disp_valid_o,
  output logic [FU_W-1:0]  disp_fu_o,
  output logic [REG_W-1:0] disp_dst_o,
  output logic [REG_W-1:0] disp_src1_o,
  output logic [REG_W-1:0] disp_src2_o,
  output logic             full_o
);
  typedef struct packed {
    logic [FU_W-1:0]  fu;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] s1;
    logic [REG_W-1:0] s2;
    logic             r1;
    logic             r2;
  } ent_t;

  ent_t             ent_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] elig, gnt, free_v, ins_oh, ins_mask, keep;
  logic [NREG-1:0]  pend;
  logic             war, waw, ins, new_r1, new_r2;

  ib_pend_track #(.NREG(NREG)) u_pend (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_v_i  (ins),
    .set_reg_i(in_dst_i),
    .clr_v_i  (wb_valid_i),
    .clr_reg_i(wb_reg_i),
    .pend_o   (pend)
  );

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      elig[i] = vld_q[i] && ent_q[i].r1 && ent_q[i].r2 && !fu_busy_i[ent_q[i].fu];
  end

  ib_age_arb #(.DEPTH(DEPTH)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ins_oh_i(ins_mask),
    .keep_i  (keep),
    .req_i   (elig),
    .gnt_o   (gnt)
  );

  // entry hazards against the offered instruction
  always_comb begin
    war = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && (ent_q[i].s1 == in_dst_i || ent_q[i].s2 == in_dst_i)) war = 1'b1;
  end
  assign waw = pend[in_dst_i];

  // lowest free slot, counting the one leaving this cycle
  assign free_v = ~vld_q | gnt;
  always_comb begin
    logic found;
    found  = 1'b0;
    ins_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (free_v[i] && !found) begin
        ins_oh[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  assign in_ready_o = (|free_v) && !war && !waw;
  assign ins        = in_valid_i && in_ready_o;
  assign ins_mask   = ins_oh & {DEPTH{ins}};
  assign keep       = vld_q & ~gnt;

  assign new_r1 = !pend[in_src1_i] || (wb_valid_i && wb_reg_i == in_src1_i);
  assign new_r2 = !pend[in_src2_i] || (wb_valid_i && wb_reg_i == in_src2_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_mask[i]) begin
          vld_q[i]    <= 1'b1;
          ent_q[i].fu  <= in_fu_i;
          ent_q[i].dst <= in_dst_i;
          ent_q[i].s1  <= in_src1_i;
          ent_q[i].s2  <= in_src2_i;
          ent_q[i].r1  <= new_r1;
          ent_q[i].r2  <= new_r2;
        end else if (gnt[i]) begin
          vld_q[i] <= 1'b0;
        end else if (wb_valid_i && vld_q[i]) begin
          if (ent_q[i].s1 == wb_reg_i) ent_q[i].r1 <= 1'b1;
          if (ent_q[i].s2 == wb_reg_i) ent_q[i].r2 <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    disp_fu_o   = '0;
    disp_dst_o  = '0;
    disp_src1_o = '0;
    disp_src2_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (gnt[i]) begin
        disp_fu_o   = disp_fu_o   | ent_q[i].fu;
        disp_dst_o  = disp_dst_o  | ent_q[i].dst;
        disp_src1_o = disp_src1_o | ent_q[i].s1;
        disp_src2_o = disp_src2_o | ent_q[i].s2;
      end
    end
  end

  assign disp_valid_o = |gnt;
  assign full_o       = &vld_q;
endmodule

// File: rtl/ooo_issue_buf_chk.sv
module ooo_issue_buf_chk #(
  parameter int unsigned NREG = ib_pkg::IB_NREG,
  parameter int unsigned NFU  = ib_pkg::IB_NFU,
  localparam int unsigned REG_W = $clog2(NREG),
  localparam int unsigned FU_W  = $clog2(NFU)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [REG_W-1:0] in_dst_i,
  input logic             wb_valid_i,
  input logic [REG_W-1:0] wb_reg_i,
  input logic [NFU-1:0]   fu_busy_i,
  input logic             disp_valid_o,
  input logic [FU_W-1:0]  disp_fu_o,
  input logic [REG_W-1:0] disp_dst_o,
  input logic [REG_W-1:0] disp_src1_o,
  input logic [REG_W-1:0] disp_src2_o,
  input logic             full_o
);
  logic [NREG-1:0] sh_pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_pend <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (in_valid_i && in_ready_o && in_dst_i == REG_W'(r)) sh_pend[r] <= 1'b1;
        else if (wb_valid_i && wb_reg_i == REG_W'(r))          sh_pend[r] <= 1'b0;
      end
    end
  end

  AST_NO_WAW_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |-> !sh_pend[in_dst_i]); // R4

  AST_FU_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o |-> !fu_busy_i[disp_fu_o]); // R7

  AST_FULL_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !disp_valid_o |-> !in_ready_o); // R2

  AST_SRC1_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && disp_src1_o != disp_dst_o |-> !sh_pend[disp_src1_o]); // R5

  AST_SRC2_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_valid_o && disp_src2_o != disp_dst_o |-> !sh_pend[disp_src2_o]); // R5
endmodule

bind ooo_issue_buf ooo_issue_buf_chk #(.NREG(NREG), .NFU(NFU)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_dst_i    (in_dst_i),
  .wb_valid_i  (wb_valid_i),
  .wb_reg_i    (wb_reg_i),
  .fu_busy_i   (fu_busy_i),
  .disp_valid_o(disp_valid_o),
  .disp_fu_o   (disp_fu_o),
  .disp_dst_o  (disp_dst_o),
  .disp_src1_o (disp_src1_o),
  .disp_src2_o (disp_src2_o),
  .full_o      (full_o)
);

// File: tb/ooo_issue_buf_tb.sv
module ooo_issue_buf_tb;
  localparam int DEPTH = 4;
  localparam int NREG  = 8;
  localparam int NFU   = 4;
  localparam int REG_W = $clog2(NREG);
  localparam int FU_W  = $clog2(NFU);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             in_valid_i = 1'b0;
  logic             in_ready_o;
  logic [FU_W-1:0]  in_fu_i = '0;
  logic [REG_W-1:0] in_dst_i = '0, in_src1_i = '0, in_src2_i = '0;
  logic             wb_valid_i = 1'b0;
  logic [REG_W-1:0] wb_reg_i = '0;
  logic [NFU-1:0]   fu_busy_i = '0;
  logic             disp_valid_o;
  logic [FU_W-1:0]  disp_fu_o;
  logic [REG_W-1:0] disp_dst_o, disp_src1_o, disp_src2_o;
  logic             full_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ooo_issue_buf #(.DEPTH(DEPTH), .NREG(NREG), .NFU(NFU)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid_i), .in_ready_o(in_ready_o), .in_fu_i(in_fu_i),
    .in_dst_i(in_dst_i), .in_src1_i(in_src1_i), .in_src2_i(in_src2_i),
    .wb_valid_i(wb_valid_i), .wb_reg_i(wb_reg_i), .fu_busy_i(fu_busy_i),
    .disp_valid_o(disp_valid_o), .disp_fu_o(disp_fu_o), .disp_dst_o(disp_dst_o),
    .disp_src1_o(disp_src1_o), .disp_src2_o(disp_src2_o), .full_o(full_o)
  );

  // reference model: entries kept oldest first
  int m_n = 0;
  int m_fu [DEPTH];
  int m_dst[DEPTH];
  int m_s1 [DEPTH];
  int m_s2 [DEPTH];
  bit m_r1 [DEPTH];
  bit m_r2 [DEPTH];
  bit [NREG-1:0] pend = '0;
  bit [NREG-1:0] infl = '0;

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int pick_disp(input bit [NFU-1:0] busy);
    for (int k = 0; k < m_n; k++)
      if (m_r1[k] && m_r2[k] && !busy[m_fu[k]]) return k;
    return -1;
  endfunction

  task automatic step(input bit iv, input int fu, input int dst, input int s1, input int s2,
                      input bit [NFU-1:0] busy, input bit wv, input int wr, input string note);
    int  k;
    bit  war, waw, rdy, blocked;
    @(negedge clk);
    in_valid_i = iv; in_fu_i = FU_W'(fu); in_dst_i = REG_W'(dst);
    in_src1_i = REG_W'(s1); in_src2_i = REG_W'(s2);
    fu_busy_i = busy; wb_valid_i = wv; wb_reg_i = REG_W'(wr);
    #1;
    k = pick_disp(busy);
    war = 1'b0;
    for (int i = 0; i < m_n; i++) if (m_s1[i] == dst || m_s2[i] == dst) war = 1'b1;
    waw = pend[dst];
    rdy = (m_n < DEPTH || k >= 0) && !war && !waw;
    blocked = 1'b0;
    for (int i = 0; i < m_n; i++) if (m_r1[i] && m_r2[i]) blocked = 1'b1;
    chk("R2", int'(full_o), int'(m_n == DEPTH), {"full ", note});
    if (war)                       chk("R3", int'(in_ready_o), int'(rdy), {"ready ", note});
    else if (waw)                  chk("R4", int'(in_ready_o), int'(rdy), {"ready ", note});
    else if (m_n == DEPTH && k >= 0) chk("R9", int'(in_ready_o), int'(rdy), {"ready ", note});
    else                           chk("R2", int'(in_ready_o), int'(rdy), {"ready ", note});
    if (k >= 0) begin
      chk("R6", int'(disp_valid_o), 1, {"disp_valid ", note});
      chk("R6", int'(disp_fu_o),   m_fu[k],  {"disp_fu ", note});
      chk("R6", int'(disp_dst_o),  m_dst[k], {"disp_dst ", note});
      chk("R6", int'(disp_src1_o), m_s1[k],  {"disp_src1 ", note});
      chk("R6", int'(disp_src2_o), m_s2[k],  {"disp_src2 ", note});
    end else begin
      chk(blocked ? "R7" : "R5", int'(disp_valid_o), 0, {"disp_valid ", note});
    end
    // advance the model to the state after this edge
    if (wv) begin
      pend[wr] = 1'b0; infl[wr] = 1'b0;
      for (int i = 0; i < m_n; i++) begin
        if (m_s1[i] == wr) m_r1[i] = 1'b1;
        if (m_s2[i] == wr) m_r2[i] = 1'b1;
      end
    end
    if (k >= 0) begin
      infl[m_dst[k]] = 1'b1;
      for (int i = k; i < m_n - 1; i++) begin
        m_fu[i] = m_fu[i+1]; m_dst[i] = m_dst[i+1]; m_s1[i] = m_s1[i+1];
        m_s2[i] = m_s2[i+1]; m_r1[i] = m_r1[i+1]; m_r2[i] = m_r2[i+1];
      end
      m_n--;
    end
    if (iv && rdy) begin
      m_fu[m_n] = fu; m_dst[m_n] = dst; m_s1[m_n] = s1; m_s2[m_n] = s2;
      m_r1[m_n] = !pend[s1];   // wb of this cycle already cleared above
      m_r2[m_n] = !pend[s2];
      pend[dst] = 1'b1;
      m_n++;
    end
  endtask

  task automatic idle_wb(input int wr, input string note);
    step(1'b0, 0, 0, 0, 0, '0, 1'b1, wr, note);
  endtask

  task automatic drain();
    for (int c = 0; c < 200 && (m_n > 0 || infl != 0); c++) begin
      int wr;
      bit wv;
      wr = -1;
      for (int r = 0; r < NREG; r++) if (infl[r] && wr < 0) wr = r;
      wv = (wr >= 0);
      step(1'b0, 0, 0, 0, 0, '0, wv, wv ? wr : 0, "drain");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R1: empty after reset
    chk("R1", int'(in_ready_o), 1, "reset ready");
    chk("R1", int'(full_o), 0, "reset full");
    chk("R1", int'(disp_valid_o), 0, "reset disp");

    // R10: source equal to own destination
    step(1'b1, 0, 1, 1, 1, '0, 1'b0, 0, "R10 insert");
    step(1'b0, 0, 0, 0, 0, '0, 1'b0, 0, "R10 dispatch");
    idle_wb(1, "R10 wb");

    // R8: consumer wakes the cycle after write-back
    step(1'b1, 1, 2, 0, 0, '0, 1'b0, 0, "R8 producer");
    step(1'b1, 2, 3, 2, 2, '0, 1'b0, 0, "R8 consumer");
    step(1'b0, 0, 0, 0, 0, '0, 1'b0, 0, "R8 waiting");
    idle_wb(2, "R8 wb cycle");
    step(1'b0, 0, 0, 0, 0, '0, 1'b0, 0, "R8 wake");
    idle_wb(3, "R8 drain");

    // R2/R9/R7: fill with all units busy, then reuse a freed slot
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, i % NFU, 4 + i, 0, 0, '1, 1'b0, 0, "R7 fill");
    step(1'b1, 0, 1, 0, 0, '1, 1'b0, 0, "R2 full refuse");
    step(1'b1, 0, 1, 0, 0, 4'b1110, 1'b0, 0, "R9 reuse");
    // R3: destination read by a held entry
    step(1'b1, 1, 0, 2, 2, 4'b1111, 1'b0, 0, "R3 war");
    // R4: destination already pending
    step(1'b1, 1, 5, 2, 2, 4'b1111, 1'b0, 0, "R4 waw");
    drain();

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      bit iv, wv;
      int wr;
      bit [NFU-1:0] busy;
      iv = ($urandom % 100) < 70;
      busy = '0;
      for (int u = 0; u < NFU; u++) busy[u] = ($urandom % 100) < 30;
      wr = $urandom % NREG;
      wv = infl[wr] && (($urandom % 100) < 50);
      step(iv, $urandom % NFU, $urandom % NREG, $urandom % NREG, $urandom % NREG,
           busy, wv, wr, "random");
    end
    drain();
    chk("R2", int'(full_o), 0, "final empty");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule